// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block produces the strobe timing of an 8-bit processor's external machine cycles. A client presents a request made of a cycle kind, an address and, for writes, a data byte. The block then steps through one T-state per clock. It drives the address bus and the active-low strobes: memory request, I/O request, read, write, first-machine-cycle marker and refresh marker. It stretches the cycle while the active-low wait input is held low, and it returns the read byte together with a one-clock completion pulse.

An opcode fetch ends with a two-state refresh phase. In that phase the address bus carries the interrupt-vector page input on its upper byte and a refresh counter on its lower byte. Every I/O cycle gets one wait state automatically. All outputs are registered. A request is taken only while the sequencer is idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and after reset, every strobe output is high (inactive), `done` is low and `ready` is high.
- R2: A `req_type` of 1 (memory read), or any code from 5 to 7, runs a three-T-state cycle (T1, T2, T3). `mreq_n` and `rd_n` are low for all three states and the address is on `addr` from T1. `done` pulses high in the following clock, with `rdata` holding the `din` value sampled on the edge that ends T3.
- R3: A `req_type` of 0 (opcode fetch) holds `m1_n`, `mreq_n` and `rd_n` low together from T1 through T2 and any wait states.
- R4: The fetch then has a refresh phase of two T-states (T3, T4). In it `mreq_n` and `rfsh_n` are low, `rd_n` and `m1_n` are high, and `addr` equals {`ireg`, refresh counter}. A fetch without waits lasts four T-states.
- R5: The refresh counter starts at 0 after reset. Its low 7 bits increment by one after each fetch and wrap from 127 to 0. Its bit 7 keeps its value (0).
- R6: A `req_type` of 2 (memory write) holds `mreq_n` low for T1 to T3 and `dout_oe` high with `dout` = `req_wdata` for T1 to T3. `wr_n` is low only in T2 and T3.
- R7: A `req_type` of 3 (I/O read) or 4 (I/O write) never asserts `mreq_n`. It asserts `iorq_n` together with `rd_n` (read) or `wr_n` (write) from T2 until the last T-state, and always inserts one wait state, so it lasts four T-states when `wait_n` stays high.
- R8: `wait_n` is sampled on the edge that ends T2 and on the edge that ends each wait state. Each low sample adds one more wait state. For I/O cycles a low sample at T2 coincides with the automatic wait state and adds nothing.
- R9: For a fetch, `rdata` holds the `din` value sampled on the edge that ends the last read T-state (T2 or the last wait state). Later changes of `din` during refresh do not affect it.
- R10: `ready` is low from T1 until the cycle ends. A `req_valid` raised while not ready is ignored: the running cycle keeps its kind and no cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while `ready` is high |
| req_type | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| ireg | input | ADDR_W-8 | Upper address byte during refresh |
| wait_n | input | 1 | Active-low wait request |
| din | input | DATA_W | Data bus input |
| ready | output | 1 | Sequencer idle |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Captured read data |
| addr | output | ADDR_W | Address bus |
| dout | output | DATA_W | Write data bus |
| dout_oe | output | 1 | Write data bus enable |
| mreq_n | output | 1 | Memory request, active low |
| iorq_n | output | 1 | I/O request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | Opcode fetch marker, active low |
| rfsh_n | output | 1 | Refresh marker, active low |

## Verification
The automatic I/O wait state and an external wait request can land on the same T-state: the T2 sample of `wait_n` falls on the clock where an I/O cycle already enters its built-in wait. The bench drives `wait_n` low only across T2 of an I/O cycle and expects four T-states, not five. It then holds `wait_n` low across T2 and the automatic wait and expects exactly one added state. In a fetch, data capture and the start of refresh share one edge; this is checked by changing `din` as soon as refresh appears and confirming that `rdata` keeps the earlier byte.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  localparam logic [2:0] CY_FETCH = 3'd0;
  localparam logic [2:0] CY_MRD   = 3'd1;
  localparam logic [2:0] CY_MWR   = 3'd2;
  localparam logic [2:0] CY_IORD  = 3'd3;
  localparam logic [2:0] CY_IOWR  = 3'd4;

  typedef enum logic [2:0] {
    TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3, TS_T4
  } tstate_e;

  function automatic logic [2:0] norm_kind(input logic [2:0] k);
    return (k > CY_IOWR) ? CY_MRD : k;
  endfunction

  function automatic logic kind_is_io(input logic [2:0] k);
    return (k == CY_IORD) || (k == CY_IOWR);
  endfunction
endpackage

// File: rtl/bcs_tstate_fsm.sv
`timescale 1ns/1ps
module bcs_tstate_fsm
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wait_n,
  output tstate_e           state_q,
  output tstate_e           nxt_state,
  output logic [2:0]        kind_q,
  output logic [2:0]        nxt_kind,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [DATA_W-1:0] nxt_wdata,
  output logic              capture,
  output logic              finish
);
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              is_fetch;

  assign accept    = (state_q == TS_IDLE) && req_valid;
  assign nxt_kind  = accept ? norm_kind(req_type) : kind_q;
  assign nxt_addr  = accept ? req_addr : addr_q;
  assign nxt_wdata = accept ? req_wdata : wdata_q;
  assign is_fetch  = (kind_q == CY_FETCH);

  always_comb begin
    nxt_state = state_q;
    unique case (state_q)
      TS_IDLE: nxt_state = req_valid ? TS_T1 : TS_IDLE;
      TS_T1:   nxt_state = TS_T2;
      TS_T2:   nxt_state = (kind_is_io(kind_q) || !wait_n) ? TS_TW : TS_T3;
      TS_TW:   nxt_state = !wait_n ? TS_TW : TS_T3;
      TS_T3:   nxt_state = is_fetch ? TS_T4 : TS_IDLE;
      TS_T4:   nxt_state = TS_IDLE;
      default: nxt_state = TS_IDLE;
    endcase
  end

  // read byte is taken on the edge ending the last read T-state
  assign capture = is_fetch
                 ? (((state_q == TS_T2) || (state_q == TS_TW)) && (nxt_state == TS_T3))
                 : ((state_q == TS_T3) && ((kind_q == CY_MRD) || (kind_q == CY_IORD)));
  assign finish  = (nxt_state == TS_IDLE) && (state_q != TS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_IDLE;
      kind_q  <= CY_MRD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= nxt_state;
      kind_q  <= nxt_kind;
      addr_q  <= nxt_addr;
      wdata_q <= nxt_wdata;
    end
  end
endmodule

// File: rtl/bcs_refresh_ctr.sv
`timescale 1ns/1ps
module bcs_refresh_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] cnt
);
  localparam int LOW_W = CNT_W - 1;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (bump)
      cnt <= {cnt[CNT_W-1], cnt[LOW_W-1:0] + LOW_W'(1)};
  end
endmodule

// File: rtl/bcs_strobe_gen.sv
`timescale 1ns/1ps
module bcs_strobe_gen
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  tstate_e                 nxt_state,
  input  logic [2:0]              nxt_kind,
  input  logic [ADDR_W-1:0]       nxt_addr,
  input  logic [DATA_W-1:0]       nxt_wdata,
  input  logic [ADDR_W-CNT_W-1:0] ireg,
  input  logic [CNT_W-1:0]        rcnt,
  input  logic [DATA_W-1:0]       din,
  input  logic                    capture,
  input  logic                    finish,
  output logic                    ready,
  output logic                    done,
  output logic [DATA_W-1:0]       rdata,
  output logic [ADDR_W-1:0]       addr,
  output logic [DATA_W-1:0]       dout,
  output logic                    dout_oe,
  output logic                    mreq_n,
  output logic                    iorq_n,
  output logic                    rd_n,
  output logic                    wr_n,
  output logic                    m1_n,
  output logic                    rfsh_n
);
  logic act, early, late, rfsh_ph, is_mem, is_wr;
  logic m1_d, mreq_d, iorq_d, rd_d, wr_d;

  always_comb begin
    act     = (nxt_state != TS_IDLE);
    early   = (nxt_state == TS_T1) || (nxt_state == TS_T2) || (nxt_state == TS_TW);
    late    = (nxt_state == TS_T2) || (nxt_state == TS_TW) || (nxt_state == TS_T3);
    rfsh_ph = (nxt_kind == CY_FETCH) && ((nxt_state == TS_T3) || (nxt_state == TS_T4));
    is_mem  = !kind_is_io(nxt_kind);
    is_wr   = (nxt_kind == CY_MWR) || (nxt_kind == CY_IOWR);
    m1_d    = (nxt_kind == CY_FETCH) && early;
    mreq_d  = is_mem && act;
    iorq_d  = !is_mem && late;
    rd_d    = m1_d || ((nxt_kind == CY_MRD) && act) || ((nxt_kind == CY_IORD) && late);
    wr_d    = is_wr && late;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b1;
      done    <= 1'b0;
      rdata   <= '0;
      addr    <= '0;
      dout    <= '0;
      dout_oe <= 1'b0;
      mreq_n  <= 1'b1;
      iorq_n  <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      m1_n    <= 1'b1;
      rfsh_n  <= 1'b1;
    end else begin
      ready   <= !act;
      done    <= finish;
      if (capture) rdata <= din;
      if (rfsh_ph)  addr <= {ireg, rcnt};
      else if (act) addr <= nxt_addr;
      dout_oe <= is_wr && act;
      if (is_wr && act) dout <= nxt_wdata;
      mreq_n  <= !mreq_d;
      iorq_n  <= !iorq_d;
      rd_n    <= !rd_d;
      wr_n    <= !wr_d;
      m1_n    <= !m1_d;
      rfsh_n  <= !rfsh_ph;
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-9:0] ireg,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] din,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              rfsh_n
);
  localparam int CNT_W = 8;

  tstate_e           state_q, nxt_state;
  logic [2:0]        kind_q, nxt_kind;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_wdata;
  logic              capture, finish;
  logic [CNT_W-1:0]  rfsh_cnt;

  bcs_tstate_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .wait_n(wait_n),
    .state_q(state_q), .nxt_state(nxt_state), .kind_q(kind_q),
    .nxt_kind(nxt_kind), .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata),
    .capture(capture), .finish(finish)
  );

  bcs_refresh_ctr #(.CNT_W(CNT_W)) u_rctr (
    .clk(clk), .rst(rst), .bump(state_q == TS_T4), .cnt(rfsh_cnt)
  );

  bcs_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_strb (
    .clk(clk), .rst(rst), .nxt_state(nxt_state), .nxt_kind(nxt_kind),
    .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata), .ireg(ireg), .rcnt(rfsh_cnt),
    .din(din), .capture(capture), .finish(finish), .ready(ready), .done(done),
    .rdata(rdata), .addr(addr), .dout(dout), .dout_oe(dout_oe),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .rfsh_n(rfsh_n)
  );
endmodule

// File: rtl/bcs_checker.sv
`timescale 1ns/1ps
module bcs_checker (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       dout_oe,
  input logic       mreq_n,
  input logic       iorq_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       m1_n,
  input logic       rfsh_n,
  input logic [7:0] rfsh_cnt
);
  a_r3_m1_with_read: assert property (@(posedge clk) disable iff (rst)
    !m1_n |-> (!mreq_n && !rd_n));

  a_r4_refresh_quiet: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n |-> (!mreq_n && rd_n && wr_n && m1_n));

  a_r7_space_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mreq_n && !iorq_n));

  a_r6_wr_with_data: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> dout_oe);

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_bit7_held: assert property (@(posedge clk) disable iff (rst)
    $stable(rfsh_cnt[7]));

  a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (rfsh_cnt != $past(rfsh_cnt)) |-> (rfsh_cnt[6:0] == 7'($past(rfsh_cnt[6:0]) + 7'd1)));
endmodule

bind bus_cycle_seq bcs_checker u_bcs_checker (
  .clk(clk), .rst(rst), .done(done), .dout_oe(dout_oe), .mreq_n(mreq_n),
  .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n),
  .rfsh_cnt(rfsh_cnt)
);

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_type;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  ireg;
  logic        wait_n;
  logic [7:0]  din;
  logic        ready, done, dout_oe, mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n;
  logic [7:0]  rdata, dout;
  logic [15:0] addr;

  always #2.5 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .ireg(ireg), .wait_n(wait_n),
    .din(din), .ready(ready), .done(done), .rdata(rdata), .addr(addr),
    .dout(dout), .dout_oe(dout_oe), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int ncyc;
  logic [7:0] got_rdata;
  logic [6:0] exp_cnt = 7'd0;
  logic tr_mreq[32], tr_iorq[32], tr_rd[32], tr_wr[32], tr_m1[32], tr_rfsh[32];
  logic tr_oe[32], tr_ready[32];
  logic [15:0] tr_addr[32];
  logic [7:0]  tr_dout[32];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one machine cycle; wlow bit k pulls wait_n low during T-state k
  task automatic run(input logic [2:0] t, input logic [15:0] a, input logic [7:0] wd,
                     input logic [7:0] dv, input logic [31:0] wlow, input bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_wdata = wd; din = dv; wait_n = 1'b1;
    ncyc = -1;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      req_valid = poke && (k == 0);
      if (poke) req_type = 3'd0;
      tr_mreq[k] = mreq_n; tr_iorq[k] = iorq_n; tr_rd[k] = rd_n; tr_wr[k] = wr_n;
      tr_m1[k] = m1_n; tr_rfsh[k] = rfsh_n; tr_oe[k] = dout_oe; tr_ready[k] = ready;
      tr_addr[k] = addr; tr_dout[k] = dout;
      if (done) begin
        ncyc = k; got_rdata = rdata;
        break;
      end
      if (!rfsh_n) din = ~dv;
      wait_n = ~wlow[k];
    end
    req_valid = 1'b0; wait_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n, "R1 strobes idle",
        {mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}, 6'h3f);
    chk(!done && ready, "R1 done/ready", {done, ready}, 2'b01);
  endtask

  task automatic t_memrd(input logic [2:0] code, input logic [31:0] wlow, input int nexp);
    bit ok = 1;
    run(code, 16'h1234, 8'h00, 8'hA5, wlow, 0);
    chk(ncyc == nexp, "R2/R8 memory read length", ncyc, nexp);
    for (int k = 0; k < nexp; k++)
      if (tr_mreq[k] || tr_rd[k] || !tr_iorq[k] || !tr_m1[k] || !tr_wr[k] || !tr_rfsh[k]) ok = 0;
    chk(ok, "R2 read strobes", ok, 1);
    chk(tr_addr[0] == 16'h1234, "R2 address", tr_addr[0], 16'h1234);
    chk(got_rdata == 8'hA5, "R2 read data", got_rdata, 8'hA5);
    chk(tr_mreq[nexp] && tr_rd[nexp], "R2 release", {tr_mreq[nexp], tr_rd[nexp]}, 2'b11);
  endtask

  task automatic t_fetch(input int w, input logic [15:0] a, input logic [7:0] dv);
    bit ok = 1;
    logic [15:0] ra;
    logic [31:0] wlow = '0;
    for (int i = 0; i < w; i++) wlow[1+i] = 1'b1;
    ra = {ireg, 1'b0, exp_cnt};
    run(3'd0, a, 8'h00, dv, wlow, 0);
    chk(ncyc == 4 + w, "R4 fetch length", ncyc, 4 + w);
    for (int k = 0; k < 2 + w; k++)
      if (tr_m1[k] || tr_mreq[k] || tr_rd[k] || !tr_rfsh[k]) ok = 0;
    chk(ok && tr_addr[0] == a, "R3 fetch strobes", tr_addr[0], a);
    ok = 1;
    for (int k = 2 + w; k < 4 + w; k++)
      if (tr_mreq[k] || tr_rfsh[k] || !tr_rd[k] || !tr_m1[k] || tr_addr[k] != ra) ok = 0;
    chk(ok, "R4/R5 refresh phase addr", tr_addr[2+w], ra);
    chk(got_rdata == dv, "R9 fetch data before refresh", got_rdata, dv);
    exp_cnt = exp_cnt + 7'd1;
  endtask

  task automatic t_memwr();
    bit ok = 1;
    run(3'd2, 16'h8001, 8'h3C, 8'h00, 0, 0);
    chk(ncyc == 3, "R6 write length", ncyc, 3);
    for (int k = 0; k < 3; k++)
      if (tr_mreq[k] || !tr_oe[k] || tr_dout[k] != 8'h3C || !tr_rd[k] || !tr_iorq[k]) ok = 0;
    chk(ok, "R6 write request and data", tr_dout[0], 8'h3C);
    chk(tr_wr[0] && !tr_wr[1] && !tr_wr[2], "R6 wr timing",
        {tr_wr[0], tr_wr[1], tr_wr[2]}, 3'b100);
  endtask

  task automatic t_io(input bit is_rd, input logic [31:0] wlow, input int nexp, input string tag);
    bit ok = 1;
    run(is_rd ? 3'd3 : 3'd4, 16'h00FE, 8'h77, 8'h5A, wlow, 0);
    chk(ncyc == nexp, tag, ncyc, nexp);
    if (!tr_iorq[0] || !tr_rd[0] || !tr_wr[0]) ok = 0;
    for (int k = 0; k < nexp; k++) if (!tr_mreq[k]) ok = 0;
    for (int k = 1; k < nexp; k++)
      if (tr_iorq[k] || (is_rd ? (tr_rd[k] || !tr_wr[k]) : (tr_wr[k] || !tr_rd[k]))) ok = 0;
    chk(ok, "R7 io strobes", ok, 1);
    if (is_rd) chk(got_rdata == 8'h5A, "R7 io read data", got_rdata, 8'h5A);
  endtask

  task automatic t_busy();
    bit ok = 1;
    run(3'd1, 16'h4000, 8'h00, 8'h11, 0, 1);
    chk(ncyc == 3 && !tr_ready[0], "R10 busy request ignored", ncyc, 3);
    for (int k = 0; k < 3; k++) if (!tr_m1[k]) ok = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!mreq_n || !iorq_n || !ready) ok = 0;
    end
    chk(ok, "R10 no follow-on cycle", ok, 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 130; i++) t_fetch(0, 16'h0100, 8'(i));
    chk(exp_cnt == 7'd4, "R5 counter wrapped", exp_cnt, 7'd4);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_type = '0; req_addr = '0; req_wdata = '0;
    ireg = 8'h5C; wait_n = 1'b1; din = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_memrd(3'd1, 32'h0, 3);
    t_memrd(3'd1, 32'h6, 5);
    t_memrd(3'd7, 32'h0, 3);
    t_fetch(0, 16'h0038, 8'hC3);
    t_fetch(1, 16'h0039, 8'h3E);
    t_memwr();
    t_io(1, 32'h0, 4, "R7 io read length");
    t_io(0, 32'h2, 4, "R8 T2 wait overlaps auto wait");
    t_io(1, 32'h6, 5, "R8 io extra wait");
    t_io(0, 32'h4, 5, "R8 wait in auto state");
    t_busy();
    t_wrap();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule